// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of a byte-wide asynchronous flash device. It takes one request at a time for byte program, sector erase or chip erase. For each request it drives the unlock-and-command write cycles on the flash bus, with chip enable, write enable and output enable set for the flash's minimum pulse widths. It then reads the status bit repeatedly until the device reports that the internal operation has finished. The outcome goes back to the requester as a one-cycle response, with an error flag when the status bit kept toggling past the time limit for that kind of operation.

All bus timing is given in clock cycles through parameters. Each parameter is the nanosecond figure rounded up for the clock in use. Every write cycle has three timed phases:

- a setup phase, in which address and data are driven while write enable is high;
- a low phase of write enable;
- a high phase, in which address and data are held.

A status read has two timed phases:

- a gap, in which the data bus is released and output enable is high;
- a read phase, in which output enable is low. The status bit is sampled on its last cycle.

Top module: `flash_prog_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While an operation runs, `req_ready` stays low, chip enable is low, and further requests are not taken.
- R2: Op code 0 (byte program) issues exactly four writes, in this order: AAh to 05555h, 55h to 02AAAh, A0h to 05555h, then the request data to the request address.
- R3: Op code 2 (chip erase) issues exactly six writes, in this order: AAh to 05555h, 55h to 02AAAh, 80h to 05555h, AAh to 05555h, 55h to 02AAAh, 10h to 05555h.
- R4: Op code 1 (sector erase) issues the same first five writes as chip erase. The sixth write is 30h to the request address.
- R5: Write enable stays low for at least `WE_LOW_CYC` cycles per write. It stays high for at least `WE_HIGH_CYC` cycles between consecutive writes.
- R6: For every write cycle, the write-data enable is on, and address and write data do not change while write enable is low or on the first cycle after its rising edge.
- R7: Output enable is high whenever write enable is low. The write-data enable is off whenever output enable is low.
- R8: After the last write, the block reads the status bit repeatedly. When two consecutive reads return equal values, it gives a one-cycle `rsp_valid` with `rsp_err` = 0.
- R9: If no two consecutive reads have matched once the number of cycles spent polling reaches `PROG_TMO_CYC` (for program) or `ERASE_TMO_CYC` (for either erase), the block gives `rsp_valid` with `rsp_err` = 1. Time is counted from the first poll cycle up to and including the sample cycle.
- R10: If a read matches its predecessor on the same sample at which the time limit is reached, the response is success (`rsp_err` = 0).
- R11: During and right after reset, chip enable, output enable and write enable are high, the write-data enable is off, `req_ready` is 1 and `rsp_valid` is 0.
- R12: Op code 3 is rejected. It produces `rsp_valid` with `rsp_err` = 1 and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | ADDR_W | Target byte address or sector address |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion with error (timeout or invalid op) |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | 8 | Flash write data |
| flash_dq_oe | output | 1 | Drive enable for the write data |
| flash_tog_in | input | 1 | Bit 6 of the flash data bus, read as the status bit |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
The two functions that can land on the same cycle are completion detection and the timeout. Both are judged on the final cycle of a status read, so one sample can show a matching status bit and an expired limit at once.

The bench provokes this with a flash model whose status bit toggles for a set number of reads. That number is chosen so the first matching read falls exactly on the sample where the elapsed poll cycles reach the limit. It also uses the neighbouring count, whose match comes one read too late.

The expected outcome is computed from the poll period and the limit. The bench then compares it with `rsp_err` for program and for erase, each with its own limit.

// File: rtl/fps_pkg.sv
// Shared types and command constants for the flash command sequencer.
// Assumes a byte-wide device whose unlock addresses fit in 15 bits.
package fps_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_BAD  = 2'd3
    } fps_op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SETUP = 3'd1,
        S_WLOW  = 3'd2,
        S_WHIGH = 3'd3,
        S_PGAP  = 3'd4,
        S_PREAD = 3'd5,
        S_RESP  = 3'd6
    } fps_st_e;

    localparam logic [14:0] UNLK_A1   = 15'h5555;
    localparam logic [14:0] UNLK_A2   = 15'h2AAA;
    localparam logic [7:0]  CODE_K1   = 8'hAA;
    localparam logic [7:0]  CODE_K2   = 8'h55;
    localparam logic [7:0]  CODE_PROG = 8'hA0;
    localparam logic [7:0]  CODE_ERS  = 8'h80;
    localparam logic [7:0]  CODE_CHIP = 8'h10;
    localparam logic [7:0]  CODE_SECT = 8'h30;

endpackage

// File: rtl/fps_cmd_step.sv
// Command step decoder: gives the address and data of write number `idx`
// of the sequence for `op`. Purely combinational.
// Assumes idx never exceeds the last step of the sequence for op.
module fps_cmd_step
    import fps_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  fps_op_e           op,
    input  logic [2:0]        idx,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [ADDR_W-1:0] step_addr,
    output logic [7:0]        step_data,
    output logic              step_last
);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLK_A1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLK_A2);

    // Select the address/data pair for the current step
    always_comb begin
        step_addr = A1;
        step_data = CODE_K1;
        unique case (idx)
            3'd0: begin step_addr = A1; step_data = CODE_K1; end
            3'd1: begin step_addr = A2; step_data = CODE_K2; end
            3'd2: begin
                step_addr = A1;
                step_data = (op == OP_PROG) ? CODE_PROG : CODE_ERS;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    step_addr = tgt_addr;
                    step_data = tgt_data;
                end else begin
                    step_addr = A1;
                    step_data = CODE_K1;
                end
            end
            3'd4: begin step_addr = A2; step_data = CODE_K2; end
            3'd5: begin
                if (op == OP_SECT) begin
                    step_addr = tgt_addr;
                    step_data = CODE_SECT;
                end else begin
                    step_addr = A1;
                    step_data = CODE_CHIP;
                end
            end
            default: begin step_addr = A1; step_data = CODE_K1; end
        endcase
    end

    // Program ends after four writes, both erases after six
    assign step_last = (op == OP_PROG) ? (idx == 3'd3) : (idx == 3'd5);

endmodule

// File: rtl/fps_phase_timer.sv
// Phase timer: loaded with the length of a bus phase in cycles (>= 1),
// counts down, and flags the last cycle of the phase.
module fps_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load a new phase length or count the current one down
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt > W'(1))    cnt <= cnt - W'(1);
    end

    assign last = (cnt <= W'(1));

endmodule

// File: rtl/fps_toggle_judge.sv
// Status-bit judge: keeps the previous sampled status bit and a saturating
// count of poll cycles. It reports a match against the previous sample and
// whether the elapsed poll time (including this cycle) reached the limit.
// Assumes `start` is pulsed on the cycle before polling begins.
module fps_toggle_judge #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic          sample,
    input  logic          bit_in,
    input  logic [TW-1:0] limit,
    output logic          match,
    output logic          expired
);
    logic [TW-1:0] tmr;
    logic          prev;
    logic          have_prev;

    // Poll-time counter, cleared at start and saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                  tmr <= '0;
        else if (start)              tmr <= '0;
        else if (tick && tmr != '1)  tmr <= tmr + TW'(1);
    end

    // Remember the last sampled status bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev      <= 1'b0;
            have_prev <= 1'b0;
        end else if (start) begin
            have_prev <= 1'b0;
        end else if (sample) begin
            prev      <= bit_in;
            have_prev <= 1'b1;
        end
    end

    assign match   = have_prev && (bit_in == prev);
    assign expired = ({1'b0, tmr} + (TW+1)'(1)) >= {1'b0, limit};

endmodule

// File: rtl/flash_prog_seq.sv
// Flash program/erase sequencer top. Accepts one request, drives the
// unlock/command write cycles with parameterised strobe timing, then polls
// the status bit until two equal reads or a timeout. All timing parameters
// are in clock cycles and must be at least 1.
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int SETUP_CYC     = 1,
    parameter int WE_LOW_CYC    = 5,
    parameter int WE_HIGH_CYC   = 5,
    parameter int RD_GAP_CYC    = 1,
    parameter int RD_CYC        = 3,
    parameter int PROG_TMO_CYC  = 2750,
    parameter int ERASE_TMO_CYC = 10500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_dq_out,
    output logic              flash_dq_oe,
    input  logic              flash_tog_in,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n
);
    localparam int M1     = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
    localparam int M2     = (WE_HIGH_CYC > RD_GAP_CYC) ? WE_HIGH_CYC : RD_GAP_CYC;
    localparam int M3     = (M1 > M2) ? M1 : M2;
    localparam int PH_MAX = (M3 > RD_CYC) ? M3 : RD_CYC;
    localparam int PW     = $clog2(PH_MAX + 1);
    localparam int T_MAX  = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
    localparam int TW     = $clog2(T_MAX + 1);

    fps_st_e           st, st_n;
    fps_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [2:0]        idx, idx_n;
    logic              err_q, err_n;
    logic              ld;
    logic [PW-1:0]     ld_val;
    logic              ph_last;
    logic              accept;
    logic              poll_start, poll_tick, poll_sample;
    logic              tog_match, tog_expired;
    logic              step_last;
    logic [TW-1:0]     tmo_limit;

    fps_cmd_step #(.ADDR_W(ADDR_W)) u_step (
        .op        (op_q),
        .idx       (idx),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .step_addr (flash_addr),
        .step_data (flash_dq_out),
        .step_last (step_last)
    );

    fps_phase_timer #(.W(PW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .last     (ph_last)
    );

    assign tmo_limit = (op_q == OP_PROG) ? TW'(PROG_TMO_CYC) : TW'(ERASE_TMO_CYC);

    fps_toggle_judge #(.TW(TW)) u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (poll_start),
        .tick    (poll_tick),
        .sample  (poll_sample),
        .bit_in  (flash_tog_in),
        .limit   (tmo_limit),
        .match   (tog_match),
        .expired (tog_expired)
    );

    assign poll_tick = (st == S_PGAP) || (st == S_PREAD);
    assign req_ready = (st == S_IDLE);
    assign rsp_valid = (st == S_RESP);
    assign rsp_err   = err_q;

    // Next-state, phase loading and poll control
    always_comb begin
        st_n        = st;
        idx_n       = idx;
        err_n       = err_q;
        ld          = 1'b0;
        ld_val      = PW'(1);
        accept      = 1'b0;
        poll_start  = 1'b0;
        poll_sample = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    idx_n  = 3'd0;
                    if (fps_op_e'(req_op) == OP_BAD) begin
                        st_n  = S_RESP;
                        err_n = 1'b1;
                    end else begin
                        st_n   = S_SETUP;
                        err_n  = 1'b0;
                        ld     = 1'b1;
                        ld_val = PW'(SETUP_CYC);
                    end
                end
            end
            S_SETUP: if (ph_last) begin
                st_n = S_WLOW; ld = 1'b1; ld_val = PW'(WE_LOW_CYC);
            end
            S_WLOW: if (ph_last) begin
                st_n = S_WHIGH; ld = 1'b1; ld_val = PW'(WE_HIGH_CYC);
            end
            S_WHIGH: if (ph_last) begin
                ld = 1'b1;
                if (step_last) begin
                    st_n       = S_PGAP;
                    ld_val     = PW'(RD_GAP_CYC);
                    poll_start = 1'b1;
                end else begin
                    st_n   = S_SETUP;
                    ld_val = PW'(SETUP_CYC);
                    idx_n  = idx + 3'd1;
                end
            end
            S_PGAP: if (ph_last) begin
                st_n = S_PREAD; ld = 1'b1; ld_val = PW'(RD_CYC);
            end
            S_PREAD: if (ph_last) begin
                poll_sample = 1'b1;
                if (tog_match) begin
                    st_n  = S_RESP;
                    err_n = 1'b0;
                end else if (tog_expired) begin
                    st_n  = S_RESP;
                    err_n = 1'b1;
                end else begin
                    st_n   = S_PGAP;
                    ld     = 1'b1;
                    ld_val = PW'(RD_GAP_CYC);
                end
            end
            S_RESP:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // State, step index and result flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            idx   <= 3'd0;
            err_q <= 1'b0;
        end else begin
            st    <= st_n;
            idx   <= idx_n;
            err_q <= err_n;
        end
    end

    // Latch the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            op_q   <= fps_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Registered bus strobes decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_ce_n  <= 1'b1;
            flash_we_n  <= 1'b1;
            flash_oe_n  <= 1'b1;
            flash_dq_oe <= 1'b0;
        end else begin
            flash_ce_n  <= !(st_n inside {S_SETUP, S_WLOW, S_WHIGH, S_PGAP, S_PREAD});
            flash_we_n  <= (st_n != S_WLOW);
            flash_oe_n  <= (st_n != S_PREAD);
            flash_dq_oe <= (st_n inside {S_SETUP, S_WLOW, S_WHIGH});
        end
    end

endmodule

// File: rtl/fps_checker.sv
// Protocol checker for flash_prog_seq, attached by bind. Counts strobe
// widths itself so no property depends on a large parameter depth.
module fps_checker #(
    parameter int ADDR_W      = 18,
    parameter int WE_LOW_CYC  = 5,
    parameter int WE_HIGH_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [7:0]        flash_dq_out,
    input logic              flash_dq_oe,
    input logic              flash_ce_n,
    input logic              flash_oe_n,
    input logic              flash_we_n
);
    logic [15:0] lo_cnt, hi_cnt;

    // Count consecutive low and high samples of write enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '1;
        end else if (!flash_we_n) begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 16'd1;
        end else begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
        end
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n |-> !req_ready);

    a_r8_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r5_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (32'(lo_cnt) >= WE_LOW_CYC));

    a_r5_we_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> (32'(hi_cnt) >= WE_HIGH_CYC));

    a_r6_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |->
            ($stable(flash_addr) && $stable(flash_dq_out) && flash_dq_oe));

    a_r6_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_out) && flash_dq_oe));

    a_r7_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> flash_oe_n);

    a_r7_bus_free_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_dq_oe);

endmodule

bind flash_prog_seq fps_checker #(
    .ADDR_W      (ADDR_W),
    .WE_LOW_CYC  (WE_LOW_CYC),
    .WE_HIGH_CYC (WE_HIGH_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .flash_addr   (flash_addr),
    .flash_dq_out (flash_dq_out),
    .flash_dq_oe  (flash_dq_oe),
    .flash_ce_n   (flash_ce_n),
    .flash_oe_n   (flash_oe_n),
    .flash_we_n   (flash_we_n)
);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 18;
    localparam int SU   = 1;
    localparam int WL   = 3;
    localparam int WH   = 2;
    localparam int GAP  = 2;
    localparam int RD   = 2;
    localparam int PT   = 40;
    localparam int ET   = 80;
    localparam int PER  = GAP + RD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          rsp_valid, rsp_err;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_dq_out;
    logic          flash_dq_oe, flash_tog_in, flash_ce_n, flash_oe_n, flash_we_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_seq #(
        .ADDR_W(AW), .SETUP_CYC(SU), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH),
        .RD_GAP_CYC(GAP), .RD_CYC(RD), .PROG_TMO_CYC(PT), .ERASE_TMO_CYC(ET)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .flash_addr(flash_addr),
        .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
        .flash_tog_in(flash_tog_in), .flash_ce_n(flash_ce_n),
        .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
    );

    // ---------------- behavioural flash model ----------------
    logic [AW-1:0] wa [8];
    logic [7:0]    wd [8];
    int            wn = 0;
    int            busy_left = 0;
    int            k_arm = 0;
    logic          tog = 1'b0;
    int            viol = 0;
    realtime       t_fall = 0, t_rise = -1000;
    logic [AW-1:0] a_at_fall;
    logic [7:0]    d_at_fall;

    assign flash_tog_in = tog;

    always @(negedge flash_we_n) begin
        if (!flash_ce_n) begin
            t_fall = $realtime;
            a_at_fall = flash_addr;
            d_at_fall = flash_dq_out;
            if (t_rise >= 0 && (t_fall - t_rise) < WH * CLK_PERIOD) viol++;
            if (!flash_oe_n || !flash_dq_oe) viol++;
        end
    end

    always @(posedge flash_we_n) begin
        if (!flash_ce_n) begin
            t_rise = $realtime;
            if ((t_rise - t_fall) < WL * CLK_PERIOD) viol++;
            if (flash_addr != a_at_fall || flash_dq_out != d_at_fall) viol++;
            if (wn == 0) busy_left = k_arm;
            if (wn < 8) begin
                wa[wn] = flash_addr;
                wd[wn] = flash_dq_out;
            end
            wn++;
        end
    end

    always @(negedge flash_oe_n) begin
        if (!flash_ce_n) begin
            if (flash_dq_oe) viol++;
            if (busy_left > 0) begin
                tog = ~tog;
                busy_left--;
            end
        end
    end

    // ---------------- expected-value functions ----------------
    function automatic int exp_nw(int op);
        return (op == 0) ? 4 : (op == 3) ? 0 : 6;
    endfunction

    function automatic logic [AW-1:0] exp_addr(int op, int i, logic [AW-1:0] t);
        case (i)
            1, 4:    return 18'h02AAA;
            3:       return (op == 0) ? t : 18'h05555;
            5:       return (op == 1) ? t : 18'h05555;
            default: return 18'h05555;
        endcase
    endfunction

    function automatic logic [7:0] exp_data(int op, int i, logic [7:0] d);
        case (i)
            0:       return 8'hAA;
            1, 4:    return 8'h55;
            2:       return (op == 0) ? 8'hA0 : 8'h80;
            3:       return (op == 0) ? d : 8'hAA;
            5:       return (op == 1) ? 8'h30 : 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_err(int op, int k);
        int nm, lim, nt;
        if (op == 3) return 1'b1;
        nm  = (k + 1 > 2) ? k + 1 : 2;
        lim = (op == 0) ? PT : ET;
        nt  = (lim + PER - 1) / PER;
        return (nt < nm);
    endfunction

    task automatic check(string req, logic cond, string what, int act, int expv);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Run one request and check writes, response and bus rules
    task automatic run_op(int op, logic [AW-1:0] ad, logic [7:0] dt, int k, string tag);
        int cyc;
        int wmis;
        k_arm = k;
        wn = 0;
        viol = 0;
        t_rise = -1000;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op = 2'(op);
        req_addr = ad;
        req_data = dt;
        @(negedge clk);
        // keep offering a different request while busy; it must be ignored (R1)
        req_op = 2'(3 - op);
        req_addr = ~ad;
        if (op != 3) begin
            for (int i = 0; i < 3; i++) begin
                check("R1", req_ready == 1'b0, "ready while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(tag, rsp_valid == 1'b1, "response seen", rsp_valid, 1);
        check(tag, rsp_err == exp_err(op, k), "rsp_err", rsp_err, exp_err(op, k));
        check(tag, wn == exp_nw(op), "write count", wn, exp_nw(op));
        wmis = 0;
        for (int i = 0; i < exp_nw(op) && i < 8; i++) begin
            if (wa[i] != exp_addr(op, i, ad) || wd[i] != exp_data(op, i, dt)) begin
                wmis++;
                $display("FAIL %s write %0d actual=%0h:%0h expected=%0h:%0h", tag, i,
                         wa[i], wd[i], exp_addr(op, i, ad), exp_data(op, i, dt));
            end
        end
        if (wmis != 0) n_fail++;
        n_tests++;
        check("R5 R6 R7", viol == 0, "strobe rule violations", viol, 0);
        @(negedge clk);
        check("R8", rsp_valid == 1'b0, "response single cycle", rsp_valid, 0);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R11", flash_ce_n && flash_we_n && flash_oe_n, "strobes in reset", 0, 1);
        check("R11", flash_dq_oe == 1'b0, "dq_oe in reset", flash_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", req_ready == 1'b1 && rsp_valid == 1'b0, "ready after reset", req_ready, 1);
        check("R11", flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "idle bus", 0, 1);

        // Directed sequences
        run_op(0, 18'h3C123, 8'h5A, 3, "R2");
        run_op(2, 18'h00000, 8'h00, 5, "R3");
        run_op(1, 18'h21000, 8'hFF, 4, "R4");
        run_op(3, 18'h11111, 8'h11, 0, "R12");
        run_op(0, 18'h00010, 8'h00, 0, "R8");
        // Timeout and tie with completion: program limit 40 cycles, period 4
        run_op(0, 18'h00020, 8'h33, 9,  "R10");
        run_op(0, 18'h00021, 8'h34, 10, "R9");
        // Erase has its own limit of 80 cycles
        run_op(1, 18'h3A000, 8'h00, 10, "R9");
        run_op(2, 18'h00000, 8'h00, 19, "R10");
        run_op(2, 18'h00000, 8'h00, 20, "R9");

        // Random requests
        for (int i = 0; i < 24; i++) begin
            int op;
            int k;
            op = int'($urandom_range(0, 3));
            k  = int'($urandom_range(0, 22));
            run_op(op, AW'($urandom), 8'($urandom), k, "R2 R3 R4 R9");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule